// File: doc/BRIEF.md
# Drink Vending Credit Controller

This block keeps the running credit of a four-drink vending machine. Coin pulses worth 5, 10 and 50 raise the credit, which saturates at 100. Four affordability flags show which drinks the current credit can pay for. A one-cycle selection pulse buys one drink and deducts its price. Any credit left over is then paid back by lowering it by 5 once per refund period until it reaches zero. A cancel pulse pays back the whole credit with the same countdown.

The credit is also presented as three decimal digits. Each digit has a blank flag, so leading zeros are hidden. Keyboard decoding, button debouncing and segment multiplexing sit outside the block. Every command input is a clean pulse that lasts one clock cycle. The refund period is a parameter counted in clock cycles, so a simulation can use a short period.

Top module: `vend_credit_ctrl`

## Requirements
- R1: After reset the credit is 0. The display shows a single 0: the ones digit is 0 and not blanked, the tens and hundreds digits are blanked, and all affordability flags are low.
- R2: In a cycle with no cancel and no selection, each asserted coin pulse adds its value (coin5_i adds 5, coin10_i adds 10, coin50_i adds 50). Pulses asserted in the same cycle add together, and the new credit is visible one clock edge later.
- R3: The credit never exceeds 100. A coin cycle whose sum would pass 100 leaves the credit at exactly 100.
- R4: afford_o[i] is high exactly when the price of drink i is at most the credit. The prices are drink 3 = 75, drink 2 = 50, drink 1 = 30 and drink 0 = 25.
- R5: When idle, a selection pulse on sel_i picks the highest-numbered asserted bit. If that drink is affordable, its price is deducted on the next edge. A nonzero remainder starts a refund; a zero remainder returns straight to idle.
- R6: A selection whose picked drink costs more than the credit is ignored. Coin pulses asserted in the same cycle as any selection or cancel pulse are also ignored, because cancel takes priority over selection and selection takes priority over coins.
- R7: During a refund the credit drops by 5 exactly TICK_DIV cycles after the edge that started the refund, and again every TICK_DIV cycles after that. The block returns to idle when the credit reaches 0.
- R8: When idle, cancel with a nonzero credit starts the same refund countdown from the full credit. Cancel with zero credit has no effect, and the block stays idle.
- R9: Coin, cancel and selection pulses are ignored while a refund is in progress.
- R10: The digit_o output carries the credit as BCD: hundreds in [11:8], tens in [7:4], ones in [3:0]. blank_o[2] is set when the hundreds digit is 0. blank_o[1] is set when the credit is below 10. blank_o[0] is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| coin5_i | input | 1 | One-cycle pulse: 5 inserted |
| coin10_i | input | 1 | One-cycle pulse: 10 inserted |
| coin50_i | input | 1 | One-cycle pulse: 50 inserted |
| cancel_i | input | 1 | One-cycle pulse: return all credit |
| sel_i | input | 4 | One-cycle drink selection, one bit per drink |
| afford_o | output | 4 | Drink i can be paid for with the current credit |
| digit_o | output | 12 | Credit as three BCD digits (hundreds, tens, ones) |
| blank_o | output | 3 | Per-digit blank flag, same order as digit_o |

## Verification
Every command pulse changes the credit register on the edge that samples it. The flags and digits follow that register through combinational logic only, so the bench drives each pulse at a falling edge, removes it at the next falling edge, and reads the result at that same falling edge. A refund decrement is due TICK_DIV edges after the edge that started the refund. The bench therefore counts falling edges from that point: it confirms the old value one falling edge before the decrement is due and the new value one falling edge after. Pulses sent during the countdown are checked by reading the value just before the next decrement is due.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int unsigned CREDIT_MAX  = 100;
  localparam int unsigned COIN_SMALL  = 5;
  localparam int unsigned COIN_MID    = 10;
  localparam int unsigned COIN_LARGE  = 50;
  localparam int unsigned REFUND_STEP = 5;
  localparam int unsigned N_DRINKS    = 4;
  localparam int unsigned CREDIT_W    = $clog2(CREDIT_MAX + 1);
  localparam int unsigned N_DIGITS    = 3;

  typedef logic [CREDIT_W-1:0] credit_t;

  typedef enum logic {
    MODE_IDLE   = 1'b0,
    MODE_REFUND = 1'b1
  } mode_e;

  // Price per drink index; the index order is fixed by the flag outputs.
  function automatic credit_t drink_price(input int unsigned idx);
    case (idx)
      3:       return credit_t'(75);
      2:       return credit_t'(50);
      1:       return credit_t'(30);
      default: return credit_t'(25);
    endcase
  endfunction

endpackage

// File: rtl/vend_tick_div.sv
module vend_tick_div #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = !clr && (cnt_q == LAST);

  always_comb begin
    if (clr || cnt_q == LAST) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vend_credit_core.sv
module vend_credit_core
  import vend_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                coin5_i,
  input  logic                coin10_i,
  input  logic                coin50_i,
  input  logic                cancel_i,
  input  logic [N_DRINKS-1:0] sel_i,
  input  logic                tick_i,
  output credit_t             credit_o,
  output logic                refunding_o
);
  localparam int unsigned SUM_W = CREDIT_W + 1;

  mode_e       mode_q, mode_d;
  credit_t     credit_q, credit_d;
  logic        credit_en;
  logic [SUM_W-1:0] coin_sum;
  credit_t     pick_price;

  // Highest-numbered asserted selection wins.
  always_comb begin
    pick_price = '0;
    for (int i = 0; i < N_DRINKS; i++) begin
      if (sel_i[i]) pick_price = drink_price(i);
    end
  end

  always_comb begin
    coin_sum = {1'b0, credit_q}
             + (coin5_i  ? SUM_W'(COIN_SMALL) : '0)
             + (coin10_i ? SUM_W'(COIN_MID)   : '0)
             + (coin50_i ? SUM_W'(COIN_LARGE) : '0);
  end

  always_comb begin
    mode_d   = mode_q;
    credit_d = credit_q;
    case (mode_q)
      MODE_IDLE: begin
        if (cancel_i) begin
          if (credit_q != '0) mode_d = MODE_REFUND;
        end else if (|sel_i) begin
          if (pick_price <= credit_q) begin
            credit_d = credit_q - pick_price;
            if (credit_q != pick_price) mode_d = MODE_REFUND;
          end
        end else if (coin_sum > SUM_W'(CREDIT_MAX)) begin
          credit_d = credit_t'(CREDIT_MAX);
        end else begin
          credit_d = coin_sum[CREDIT_W-1:0];
        end
      end
      default: begin
        if (tick_i) begin
          if (credit_q <= credit_t'(REFUND_STEP)) begin
            credit_d = '0;
            mode_d   = MODE_IDLE;
          end else begin
            credit_d = credit_q - credit_t'(REFUND_STEP);
          end
        end
      end
    endcase
  end

  assign credit_en = (credit_d != credit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_IDLE;
      credit_q <= '0;
    end else begin
      mode_q <= mode_d;
      if (credit_en) credit_q <= credit_d;
    end
  end

  assign credit_o    = credit_q;
  assign refunding_o = (mode_q == MODE_REFUND);
endmodule

// File: rtl/vend_digits.sv
module vend_digits
  import vend_pkg::*;
(
  input  credit_t                credit_i,
  output logic [4*N_DIGITS-1:0]  digit_o,
  output logic [N_DIGITS-1:0]    blank_o
);
  logic    hund;
  credit_t rest;
  logic [3:0] tens, ones;

  always_comb begin
    hund = (credit_i >= credit_t'(100));
    rest = credit_i - (hund ? credit_t'(100) : '0);
    tens = 4'(rest / credit_t'(10));
    ones = 4'(rest % credit_t'(10));
    digit_o = {3'b000, hund, tens, ones};
    blank_o = {!hund, (!hund && tens == 4'd0), 1'b0};
  end
endmodule

// File: rtl/vend_credit_ctrl.sv
module vend_credit_ctrl
  import vend_pkg::*;
#(
  parameter int unsigned TICK_DIV = 125_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        coin5_i,
  input  logic        coin10_i,
  input  logic        coin50_i,
  input  logic        cancel_i,
  input  logic [3:0]  sel_i,
  output logic [3:0]  afford_o,
  output logic [11:0] digit_o,
  output logic [2:0]  blank_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick;
  logic       refunding;
  credit_t    credit_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  vend_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (!refunding),
    .tick  (tick)
  );

  vend_credit_core u_core (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .coin5_i     (coin5_i),
    .coin10_i    (coin10_i),
    .coin50_i    (coin50_i),
    .cancel_i    (cancel_i),
    .sel_i       (sel_i),
    .tick_i      (tick),
    .credit_o    (credit_q),
    .refunding_o (refunding)
  );

  for (genvar g = 0; g < N_DRINKS; g++) begin : g_afford
    assign afford_o[g] = (credit_q >= drink_price(g));
  end

  vend_digits u_digits (
    .credit_i (credit_q),
    .digit_o  (digit_o),
    .blank_o  (blank_o)
  );
endmodule

// File: rtl/vend_credit_chk.sv
module vend_credit_chk
  import vend_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       coin5_i,
  input logic       coin10_i,
  input logic       coin50_i,
  input logic       cancel_i,
  input logic [3:0] sel_i,
  input logic       tick,
  input logic       refunding,
  input credit_t    credit,
  input logic [2:0] blank
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= credit_t'(CREDIT_MAX));

  p_single_coin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!refunding && !cancel_i && sel_i == 4'b0000 && coin5_i && !coin10_i
     && !coin50_i && credit <= credit_t'(95))
    |=> credit == $past(credit) + credit_t'(5));

  p_refund_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refunding && tick) |=> credit == $past(credit) - credit_t'(REFUND_STEP));

  p_refund_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (refunding && !tick) |=> $stable(credit));

  p_refund_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refunding |-> credit != '0);

  p_blank_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (blank[1] |-> blank[2]) && !blank[0]);
endmodule

bind vend_credit_ctrl vend_credit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .coin5_i   (coin5_i),
  .coin10_i  (coin10_i),
  .coin50_i  (coin50_i),
  .cancel_i  (cancel_i),
  .sel_i     (sel_i),
  .tick      (tick),
  .refunding (refunding),
  .credit    (credit_q),
  .blank     (blank_o)
);

// File: tb/test_vend_credit_ctrl.sv
module test_vend_credit_ctrl;
  localparam int unsigned DIV = 8;
  localparam int NVEC = 11;
  // {c5, c10, c50, cancel, sel[3:0], expected credit[6:0], expected flags[3:0]}
  localparam logic [18:0] VEC [0:NVEC-1] = '{
    {1'b1,1'b0,1'b0,1'b0,4'b0000,7'd5,  4'b0000},
    {1'b0,1'b1,1'b0,1'b0,4'b0000,7'd15, 4'b0000},
    {1'b1,1'b0,1'b0,1'b0,4'b0000,7'd20, 4'b0000},
    {1'b1,1'b0,1'b0,1'b0,4'b0000,7'd25, 4'b0001},
    {1'b0,1'b0,1'b0,1'b0,4'b1000,7'd25, 4'b0001},
    {1'b1,1'b0,1'b0,1'b0,4'b0000,7'd30, 4'b0011},
    {1'b0,1'b0,1'b1,1'b0,4'b0000,7'd80, 4'b1111},
    {1'b0,1'b1,1'b0,1'b0,4'b0000,7'd90, 4'b1111},
    {1'b0,1'b1,1'b0,1'b0,4'b0000,7'd100,4'b1111},
    {1'b1,1'b0,1'b0,1'b0,4'b0000,7'd100,4'b1111},
    {1'b0,1'b0,1'b1,1'b0,4'b0000,7'd100,4'b1111}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coin5_i = 1'b0, coin10_i = 1'b0, coin50_i = 1'b0, cancel_i = 1'b0;
  logic [3:0] sel_i = 4'b0000;
  logic [3:0] afford_o;
  logic [11:0] digit_o;
  logic [2:0] blank_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vend_credit_ctrl #(.TICK_DIV(DIV)) i_vend_credit_ctrl (
    .clk(clk), .rst_n(rst_n), .coin5_i(coin5_i), .coin10_i(coin10_i),
    .coin50_i(coin50_i), .cancel_i(cancel_i), .sel_i(sel_i),
    .afford_o(afford_o), .digit_o(digit_o), .blank_o(blank_o)
  );

  task automatic pulse(input logic c5, input logic c10, input logic c50,
                       input logic cn, input logic [3:0] s);
    @(negedge clk);
    coin5_i = c5; coin10_i = c10; coin50_i = c50; cancel_i = cn; sel_i = s;
    @(negedge clk);
    coin5_i = 1'b0; coin10_i = 1'b0; coin50_i = 1'b0; cancel_i = 1'b0; sel_i = 4'b0000;
  endtask

  task automatic chk(input string tag, input int exp_val, input logic [3:0] exp_led);
    int shown;
    logic [2:0] exp_blank;
    #1;
    shown = (blank_o[2] ? 0 : int'(digit_o[11:8])) * 100
          + (blank_o[1] ? 0 : int'(digit_o[7:4])) * 10 + int'(digit_o[3:0]);
    exp_blank = {exp_val < 100, exp_val < 10, 1'b0};
    checks++;
    if (shown != exp_val || afford_o != exp_led || blank_o != exp_blank) begin
      errors++;
      $display("FAIL %s: credit %0d flags %b blank %b, expected credit %0d flags %b blank %b",
               tag, shown, afford_o, blank_o, exp_val, exp_led, exp_blank);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset state", 0, 4'b0000);
    if (digit_o[3:0] != 4'd0) begin
      errors++;
      $display("FAIL R1 ones digit %0d expected 0", digit_o[3:0]);
    end
    checks++;

    for (int i = 0; i < NVEC; i++) begin
      pulse(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15], VEC[i][14:11]);
      chk($sformatf("R2/R3/R4/R6 vector %0d", i), int'(VEC[i][10:4]), VEC[i][3:0]);
    end
    checks++;
    if (digit_o != 12'h100 || blank_o != 3'b000) begin
      errors++;
      $display("FAIL R10 digits %h blank %b expected 100 000", digit_o, blank_o);
    end

    // Purchase of drink 1 from 100, then the refund countdown.
    pulse(1'b0, 1'b0, 1'b0, 1'b0, 4'b0010);
    chk("R5 purchase deducts 30", 70, 4'b0111);
    pulse(1'b0, 1'b0, 1'b1, 1'b1, 4'b1000);
    repeat (5) @(negedge clk);
    chk("R9 pulses ignored during refund", 70, 4'b0111);
    @(negedge clk);
    chk("R7 first decrement after TICK_DIV", 65, 4'b0111);
    repeat (13 * DIV) @(negedge clk);
    chk("R7 refund reaches zero", 0, 4'b0000);

    pulse(1'b1, 1'b1, 1'b0, 1'b0, 4'b0000);
    chk("R2 simultaneous coins", 15, 4'b0000);
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 4'b0001);
    chk("R6 unaffordable selection and its coin ignored", 15, 4'b0000);
    pulse(1'b0, 1'b1, 1'b0, 1'b0, 4'b0000);
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 4'b0000);
    chk("R4 credit 75", 75, 4'b1111);
    pulse(1'b0, 1'b0, 1'b0, 1'b0, 4'b1111);
    chk("R5 highest selection exact price", 0, 4'b0000);
    pulse(1'b1, 1'b0, 1'b0, 1'b0, 4'b0000);
    chk("R5 idle right after zero remainder", 5, 4'b0000);
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 4'b0000);
    chk("R10 two digits", 55, 4'b0111);

    pulse(1'b0, 1'b0, 1'b0, 1'b1, 4'b0000);
    chk("R8 cancel holds credit at start", 55, 4'b0111);
    repeat (DIV) @(negedge clk);
    chk("R8 cancel countdown step", 50, 4'b0111);
    checks++;
    if (digit_o[7:0] != 8'h50) begin
      errors++;
      $display("FAIL R10 low digits %h expected 50", digit_o[7:0]);
    end
    repeat (10 * DIV) @(negedge clk);
    chk("R8 cancel countdown done", 0, 4'b0000);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 4'b0000);
    chk("R8 cancel at zero", 0, 4'b0000);
    pulse(1'b1, 1'b0, 1'b0, 1'b0, 4'b0000);
    chk("R8 still idle after empty cancel", 5, 4'b0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule